// File: doc/BRIEF.md
# Reloadable Up-Counter with Event, Timer and Pulse-Width Modes

This block is a 16-bit up-counter with a reload value, driven from an 8-bit register port. Three register selects reach it: a high-byte register, a low-byte register and a control register. Software uses the control register to choose what makes the counter advance:
- the active edge of an external pin (event mode),
- an internal tick (timer mode),
- internal ticks during a single pulse on the external pin (pulse-width mode).

When the counter passes its top value it takes the reload value again and sets a sticky interrupt flag. The flag stays set until a dedicated clear input is pulsed.

The 16-bit value is moved in two byte accesses through a shared low-byte holding register.
- A write to the low byte only fills the holding register. The following high-byte write moves both bytes into the reload value at once.
- A read of the high byte returns the live high byte and, on the same edge, copies the live low byte into the holding register. A read of the low byte then returns that copy. A 16-bit read is therefore a consistent snapshot.

The internal tick is either one system clock in four or each rising edge of a slow real-time clock input, chosen by a static option pin. The external pin and the real-time clock are synchronised with two flops before their edges are detected.

A state machine follows the control bits. Its states are:
- ST_IDLE: no counting.
- ST_EVENT: count active edges of the external pin.
- ST_TIMER: count internal ticks.
- ST_PW_ARM: wait for the start edge.
- ST_PW_RUN: count internal ticks.

Its transitions are:
- Any state goes to ST_IDLE when the enable bit is clear or the mode is 00.
- ST_IDLE goes to the state that matches the mode when the block is enabled.
- ST_PW_ARM goes to ST_PW_RUN on the start edge.
- ST_PW_RUN goes to ST_IDLE on the return edge, and the enable bit clears on that same edge.
- ST_PW_ARM and ST_PW_RUN go directly to ST_EVENT or ST_TIMER if the mode is rewritten while enabled.

Top module: `ptmr_core`

## Requirements
- R1: After reset the counter, reload value, holding register, control register and interrupt flag are all zero, and every register reads back 0.
- R2: A low-byte write only loads the holding register and leaves the reload value unchanged. A low-byte read returns the holding register.
- R3: A high-byte write sets the reload value to {written byte, holding register}. While the enable bit (control bit 2) is 0, the same write also loads the counter with that value. While the enable bit is 1, the counter is left unchanged.
- R4: When an advance occurs at 16'hFFFF, the counter takes the reload value and the interrupt flag sets on the same edge.
- R5: A high-byte read returns the counter's high byte and copies the counter's low byte into the holding register on the same edge. A later low-byte read returns that copy, not the live low byte.
- R6: The control register has the following fields:
  - bits 1:0 select the mode: 00 off, 01 event, 10 timer, 11 pulse-width.
  - bit 2 is the enable bit.
  - bit 3 selects the edge: 1 for rising, 0 for falling.
  - bits 7:4 read as 0.
- R7: In event mode, the counter advances by one for each selected edge of the external pin.
- R8: In timer mode, the counter advances by one per internal tick. With the option pin at 0 a tick occurs every 4 clocks. With the option pin at 1 a tick occurs on each rising edge of the real-time clock input.
- R9: In pulse-width mode, the counter does not advance until the start edge of the external pin arrives. The start edge is the selected edge. The counter then advances on internal ticks until the opposite edge, and the enable bit then clears.
- R10: After a capture, further pin edges and ticks leave the counter unchanged until software sets the enable bit again.
- R11: The interrupt flag stays set until the clear input is high at a clock edge.
- R12: With mode 00 or with the enable bit 0, neither pin activity nor ticks change the counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| use_rtc | input | 1 | Static option: 1 = tick from real-time clock edges, 0 = system clock divided by 4 |
| rtc_in | input | 1 | Slow real-time clock, asynchronous |
| ext_in | input | 1 | External event / pulse pin, asynchronous |
| sel_hi | input | 1 | Selects the high-byte register |
| sel_lo | input | 1 | Selects the low-byte register |
| sel_ctl | input | 1 | Selects the control register |
| wr_en | input | 1 | Write strobe for the selected register |
| rd_en | input | 1 | Read strobe for the selected register |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, combinational from the selects and rd_en |
| irq_clr | input | 1 | Clears the interrupt flag |
| irq_flag | output | 1 | Sticky overflow flag |

## Verification
Read data is combinational, so the bench samples rdata one nanosecond after driving a read at the falling edge. Register writes take effect at the next rising edge. A change on ext_in or rtc_in passes two synchroniser flops and one edge-detect flop, so it reaches the counter on the third rising edge after the change. The bench holds every pin level for four clocks and idles for at least six more before reading. Timer-mode sequences are measured between two high-byte reads placed exactly 4k clocks apart. The expected value is then exactly k advances from the first snapshot, whatever the prescaler phase. The bench computes that value with a reference function that includes the wrap to the reload value.

// File: rtl/ptmr_pkg.sv
package ptmr_pkg;

    typedef enum logic [1:0] {
        MODE_OFF   = 2'b00,
        MODE_EVENT = 2'b01,
        MODE_TIMER = 2'b10,
        MODE_PULSE = 2'b11
    } mode_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_EVENT,
        ST_TIMER,
        ST_PW_ARM,
        ST_PW_RUN
    } state_e;

    // control register image: bit3 edge, bit2 enable, bits1:0 mode
    typedef struct packed {
        logic  edge_rise;
        logic  enable;
        mode_e mode;
    } ctl_t;

    localparam int CTL_W = $bits(ctl_t);

endpackage

// File: rtl/ptmr_sync_edge.sv
module ptmr_sync_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic lvl,
    output logic chg
);
    logic [STAGES-1:0] shift_q;
    logic              prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shift_q <= '0;
            prev_q  <= 1'b0;
        end else begin
            shift_q <= {shift_q[STAGES-2:0], din};
            prev_q  <= shift_q[STAGES-1];
        end
    end

    assign lvl = shift_q[STAGES-1];
    assign chg = shift_q[STAGES-1] ^ prev_q;

endmodule

// File: rtl/ptmr_prescale.sv
module ptmr_prescale #(
    parameter int DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [PW-1:0] LAST = PW'(DIV - 1);

    logic [PW-1:0] div_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)            div_q <= '0;
        else if (!run)        div_q <= '0;
        else if (div_q == LAST) div_q <= '0;
        else                  div_q <= div_q + 1'b1;
    end

    assign tick = run && (div_q == LAST);

endmodule

// File: rtl/ptmr_mode_fsm.sv
module ptmr_mode_fsm
    import ptmr_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  ctl_t   ctl,
    input  logic   pin_rise,
    input  logic   pin_fall,
    input  logic   int_tick,
    output logic   count_en,
    output logic   pw_done,
    output state_e state
);
    state_e state_q, state_d;
    logic   start_edge, end_edge;

    assign start_edge = ctl.edge_rise ? pin_rise : pin_fall;
    assign end_edge   = ctl.edge_rise ? pin_fall : pin_rise;

    function automatic state_e entry_state(input mode_e m);
        unique case (m)
            MODE_EVENT: entry_state = ST_EVENT;
            MODE_TIMER: entry_state = ST_TIMER;
            MODE_PULSE: entry_state = ST_PW_ARM;
            default:    entry_state = ST_IDLE;
        endcase
    endfunction

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        if (!ctl.enable || ctl.mode == MODE_OFF) begin
            state_d = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_PW_ARM: begin
                    if (ctl.mode != MODE_PULSE) state_d = entry_state(ctl.mode);
                    else if (start_edge)       state_d = ST_PW_RUN;
                end
                ST_PW_RUN: begin
                    if (ctl.mode != MODE_PULSE) state_d = entry_state(ctl.mode);
                    else if (end_edge)         state_d = ST_IDLE;
                end
                default: state_d = entry_state(ctl.mode);
            endcase
        end
    end

    // outputs
    always_comb begin
        count_en = 1'b0;
        pw_done  = 1'b0;
        unique case (state_q)
            ST_EVENT:  count_en = start_edge;
            ST_TIMER:  count_en = int_tick;
            ST_PW_RUN: begin
                count_en = int_tick;
                pw_done  = end_edge && ctl.enable && (ctl.mode == MODE_PULSE);
            end
            default: ;
        endcase
    end

    assign state = state_q;

    // R9: a measurement only runs after the armed state saw its start edge
    a_r9_run_after_arm: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PW_RUN) |-> ($past(state_q) == ST_PW_RUN || $past(state_q) == ST_PW_ARM));

endmodule

// File: rtl/ptmr_core.sv
module ptmr_core
    import ptmr_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2,
    parameter int TICK_DIV    = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              use_rtc,
    input  logic              rtc_in,
    input  logic              ext_in,
    input  logic              sel_hi,
    input  logic              sel_lo,
    input  logic              sel_ctl,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    input  logic              irq_clr,
    output logic              irq_flag
);
    localparam int CNT_W = 2 * DATA_W;
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    ctl_t              ctl_q;
    logic [DATA_W-1:0] hold_q;
    logic [CNT_W-1:0]  reload_q, cnt_q;
    logic              flag_q;

    logic   pin_lvl, pin_chg, rtc_lvl, rtc_chg, div_tick;
    logic   pin_rise, pin_fall, int_tick;
    logic   count_en, pw_done;
    state_e fsm_state;

    logic hi_wr, lo_wr, ctl_wr, hi_rd;
    assign hi_wr  = wr_en && sel_hi;
    assign lo_wr  = wr_en && sel_lo;
    assign ctl_wr = wr_en && sel_ctl;
    assign hi_rd  = rd_en && sel_hi;

    ptmr_sync_edge #(.STAGES(SYNC_STAGES)) u_pin_sync (
        .clk(clk), .rst_n(rst_n), .din(ext_in), .lvl(pin_lvl), .chg(pin_chg));

    ptmr_sync_edge #(.STAGES(SYNC_STAGES)) u_rtc_sync (
        .clk(clk), .rst_n(rst_n), .din(rtc_in), .lvl(rtc_lvl), .chg(rtc_chg));

    ptmr_prescale #(.DIV(TICK_DIV)) u_div (
        .clk(clk), .rst_n(rst_n), .run(!use_rtc), .tick(div_tick));

    assign pin_rise = pin_chg && pin_lvl;
    assign pin_fall = pin_chg && !pin_lvl;
    assign int_tick = use_rtc ? (rtc_chg && rtc_lvl) : div_tick;

    ptmr_mode_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .ctl(ctl_q),
        .pin_rise(pin_rise), .pin_fall(pin_fall), .int_tick(int_tick),
        .count_en(count_en), .pw_done(pw_done), .state(fsm_state));

    // control register; capture end clears enable unless software writes
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       ctl_q <= '0;
        else if (ctl_wr)  ctl_q <= ctl_t'(wdata[CTL_W-1:0]);
        else if (pw_done) ctl_q.enable <= 1'b0;
    end

    // low-byte holding register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      hold_q <= '0;
        else if (lo_wr)  hold_q <= wdata;
        else if (hi_rd)  hold_q <= cnt_q[DATA_W-1:0];
    end

    // reload value, committed by the high-byte write
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      reload_q <= '0;
        else if (hi_wr)  reload_q <= {wdata, hold_q};
    end

    // counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                       cnt_q <= '0;
        else if (hi_wr && !ctl_q.enable)  cnt_q <= {wdata, hold_q};
        else if (count_en)                cnt_q <= (cnt_q == CNT_MAX) ? reload_q : cnt_q + 1'b1;
    end

    // sticky overflow flag
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                           flag_q <= 1'b0;
        else if (count_en && cnt_q == CNT_MAX) flag_q <= 1'b1;
        else if (irq_clr)                     flag_q <= 1'b0;
    end

    always_comb begin
        rdata = '0;
        if (rd_en) begin
            if (sel_hi)       rdata = cnt_q[CNT_W-1:DATA_W];
            else if (sel_lo)  rdata = hold_q;
            else if (sel_ctl) rdata = {{(DATA_W-CTL_W){1'b0}}, ctl_q};
        end
    end

    assign irq_flag = flag_q;

    // R4: an advance at the top value reloads and raises the flag
    a_r4_overflow_reload: assert property (@(posedge clk) disable iff (!rst_n)
        (count_en && cnt_q == CNT_MAX && !(hi_wr && !ctl_q.enable))
        |=> (cnt_q == $past(reload_q) && irq_flag));

    // R2: a low-byte write alone leaves the reload value alone
    a_r2_lo_keeps_reload: assert property (@(posedge clk) disable iff (!rst_n)
        (lo_wr && !hi_wr) |=> $stable(reload_q));

    // R9: the end of a capture clears the enable bit
    a_r9_capture_clears_enable: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_state == ST_PW_RUN && pw_done && !ctl_wr) |=> !ctl_q.enable);

    // R11: the flag holds until cleared
    a_r11_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_flag && !irq_clr) |=> irq_flag);

    // R12: no change while idle unless loaded by software
    a_r12_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_state == ST_IDLE && !hi_wr) |=> $stable(cnt_q));

endmodule

// File: tb/ptmr_core_test.sv
module ptmr_core_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       use_rtc = 1'b0, rtc_in = 1'b0, ext_in = 1'b0;
    logic       sel_hi = 1'b0, sel_lo = 1'b0, sel_ctl = 1'b0;
    logic       wr_en = 1'b0, rd_en = 1'b0, irq_clr = 1'b0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic       irq_flag;

    int errors = 0;
    int checks = 0;

    always #2 clk = ~clk;

    ptmr_core uut (
        .clk(clk), .rst_n(rst_n), .use_rtc(use_rtc), .rtc_in(rtc_in), .ext_in(ext_in),
        .sel_hi(sel_hi), .sel_lo(sel_lo), .sel_ctl(sel_ctl), .wr_en(wr_en), .rd_en(rd_en),
        .wdata(wdata), .rdata(rdata), .irq_clr(irq_clr), .irq_flag(irq_flag));

    localparam int SEL_HI = 0, SEL_LO = 1, SEL_CTL = 2;

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got=%h exp=%h", tag, got, exp);
        end
    endtask

    task automatic set_sel(input int s);
        sel_hi  = (s == SEL_HI);
        sel_lo  = (s == SEL_LO);
        sel_ctl = (s == SEL_CTL);
    endtask

    task automatic clr_bus();
        wr_en = 1'b0; rd_en = 1'b0; sel_hi = 1'b0; sel_lo = 1'b0; sel_ctl = 1'b0;
    endtask

    task automatic wr(input int s, input logic [7:0] d);
        @(negedge clk);
        set_sel(s); wdata = d; wr_en = 1'b1;
        @(negedge clk);
        clr_bus();
    endtask

    task automatic rd(input int s, output logic [7:0] d);
        @(negedge clk);
        set_sel(s); rd_en = 1'b1;
        #1 d = rdata;
        @(negedge clk);
        clr_bus();
    endtask

    task automatic rd16(output logic [15:0] v);
        logic [7:0] h, l;
        rd(SEL_HI, h);
        rd(SEL_LO, l);
        v = {h, l};
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic load16(input logic [15:0] v);
        wr(SEL_LO, v[7:0]);
        wr(SEL_HI, v[15:8]);
    endtask

    task automatic rtc_pulses(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk) rtc_in = 1'b1; idle(4);
            rtc_in = 1'b0; idle(4);
        end
        idle(4);
    endtask

    task automatic ext_pulses(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk) ext_in = 1'b1; idle(4);
            ext_in = 1'b0; idle(4);
        end
        idle(4);
    endtask

    function automatic logic [15:0] advance(input logic [15:0] v, input logic [15:0] pl, input int k);
        logic [15:0] r = v;
        for (int i = 0; i < k; i++) r = (r == 16'hFFFF) ? pl : r + 16'd1;
        return r;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: got=timeout exp=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [7:0]  b;
        logic [15:0] v, v0, v1, pl;
        void'($urandom(32'h5EED1234));
        idle(3);
        rst_n = 1'b1;
        idle(2);

        // R1 reset state
        rd16(v);       check("R1 counter", v, 16'h0000);
        rd(SEL_CTL, b); check("R1 control", b, 8'h00);
        check("R1 flag", irq_flag, 1'b0);

        // R6 control readback, upper bits zero
        wr(SEL_CTL, 8'hF3); rd(SEL_CTL, b); check("R6 ctl field", b, 8'h03);
        wr(SEL_CTL, 8'h00);

        // R3 load while disabled
        load16(16'h0010); rd16(v); check("R3 load when disabled", v, 16'h0010);

        // R7 event mode rising then falling
        wr(SEL_CTL, 8'h0D); ext_pulses(5);
        rd16(v); check("R7 rising edges", v, 16'h0015);
        wr(SEL_CTL, 8'h05); ext_pulses(3);
        rd16(v); check("R7 falling edges", v, 16'h0018);

        // R8 timer from rtc
        wr(SEL_CTL, 8'h00); use_rtc = 1'b1; load16(16'h0100);
        wr(SEL_CTL, 8'h06); rtc_pulses(7);
        rd16(v); check("R8 rtc ticks", v, 16'h0107);

        // R5 low read returns held copy, not live
        rtc_pulses(1);
        rd(SEL_LO, b); check("R5 stale low byte", b, 8'h07);

        // R12 mode off and enable off
        wr(SEL_CTL, 8'h04); rtc_pulses(3); ext_pulses(3);
        rd16(v); check("R12 mode 00 holds", v, 16'h0108);
        wr(SEL_CTL, 8'h02); rtc_pulses(3); ext_pulses(3);
        rd16(v); check("R12 enable 0 holds", v, 16'h0108);

        // R4 overflow, R11 sticky flag
        wr(SEL_CTL, 8'h00); load16(16'hFFFE);
        @(negedge clk) irq_clr = 1'b1; @(negedge clk) irq_clr = 1'b0;
        wr(SEL_CTL, 8'h06); rtc_pulses(1);
        rd16(v); check("R4 at top", v, 16'hFFFF); check("R4 no flag yet", irq_flag, 1'b0);
        rtc_pulses(1);
        rd16(v); check("R4 reload", v, 16'hFFFE); check("R4 flag set", irq_flag, 1'b1);
        idle(10); check("R11 flag held", irq_flag, 1'b1);
        @(negedge clk) irq_clr = 1'b1; @(negedge clk) irq_clr = 1'b0;
        check("R11 flag cleared", irq_flag, 1'b0);

        // R2 low write alone: buffer readable, reload unchanged
        wr(SEL_LO, 8'h12); rd(SEL_LO, b); check("R2 low buffer", b, 8'h12);
        rtc_pulses(2); rd16(v); check("R2 reload unchanged", v, 16'hFFFE);

        // R3 high write while enabled: reload only
        wr(SEL_LO, 8'h34); wr(SEL_HI, 8'hFF);
        rd16(v); check("R3 counter untouched", v, 16'hFFFE);
        rtc_pulses(2); rd16(v); check("R3 new reload", v, 16'hFF34);

        // R9 pulse width, rising start
        wr(SEL_CTL, 8'h00); load16(16'h0000);
        wr(SEL_CTL, 8'h0F); rtc_pulses(2);
        rd16(v); check("R9 armed no count", v, 16'h0000);
        @(negedge clk) ext_in = 1'b1; idle(6);
        rtc_pulses(5);
        @(negedge clk) ext_in = 1'b0; idle(8);
        rd16(v); check("R9 width", v, 16'h0005);
        rd(SEL_CTL, b); check("R9 enable cleared", b, 8'h0B);

        // R10 capture held
        ext_pulses(2); rtc_pulses(3);
        rd16(v); check("R10 capture held", v, 16'h0005);
        load16(16'h0000); wr(SEL_CTL, 8'h0F);
        @(negedge clk) ext_in = 1'b1; idle(6);
        rtc_pulses(3);
        @(negedge clk) ext_in = 1'b0; idle(8);
        rd16(v); check("R10 re-armed", v, 16'h0003);

        // R9 falling start
        load16(16'h0000); wr(SEL_CTL, 8'h07);
        @(negedge clk) ext_in = 1'b1; idle(6);
        rtc_pulses(2);
        @(negedge clk) ext_in = 1'b0; idle(6);
        rtc_pulses(2);
        @(negedge clk) ext_in = 1'b1; idle(8);
        rd16(v); check("R9 falling start", v, 16'h0002);
        @(negedge clk) ext_in = 1'b0; idle(6);

        // R8 divide-by-4 timer, random reloads and lengths
        use_rtc = 1'b0;
        for (int it = 0; it < 8; it++) begin
            int k;
            pl = {8'hFF, 8'($urandom)};
            k  = 1 + int'($urandom % 500);
            wr(SEL_CTL, 8'h00); load16(pl);
            wr(SEL_CTL, 8'h06);
            rd16(v0);
            idle(4 * k - 4);
            rd16(v1);
            check("R8 div4 timer", v1, advance(v0, pl, k));
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule